// File: doc/BRIEF.md
# CIC Gain Compensation Stage

This unit sits behind a cascaded integrator-comb decimator and scales its full-precision output back to the amplitude of the filter input. A decimator with rate R, differential delay M and N sections has a DC gain of G = (R·M)^N. The stage divides each sample by G without a divider. It applies a left shift that depends on the rate, then multiplies by a fixed-point reciprocal and truncates the product.

The rate travels with every sample on `in_rate`. Both correction values come from a constant table that is filled in at elaboration for every permitted rate. A rate change therefore takes effect on the very next sample. The data format is sized for the largest rate RATE_MAX. Gmax = (RATE_MAX·M)^N, SMAX = floor(log2 Gmax), and DATA_W = IN_W + ceil(log2 Gmax), which is 28 bits with the defaults (IN_W=16, RATE_MAX=16, M=1, N=3, so SMAX=12). The output is a two's-complement number with SMAX fractional bits.

Top module: `cic_gain_comp`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly 9 rising clock edges. A sample taken at edge k appears on `out_data` with `out_valid` high after edge k+9. Cycles with `in_valid` low never produce an output strobe.
- R2: For rate R, let G = (R·M)^N, s = floor(log2 G) and C = floor(2^(18+s)/G), an 18-fractional-bit reciprocal. The output is floor(x·2^(SMAX−s)·C / 2^18), written as a DATA_W-bit two's-complement value. Zero maps to zero and the sign of an in-range input is kept.
- R3: When G is an exact power of two, C equals 1.0 and the result is exactly x·2^(SMAX−s). With the defaults, rate 16 returns x unchanged and rate 4 returns x·64.
- R4: Each sample is scaled with the rate presented in the same cycle. Back-to-back samples may all carry different rates, and each one is scaled with its own rate.
- R5: A rate below 2 is treated as 2. A rate above RATE_MAX is treated as RATE_MAX.
- R6: While `rst_n` is low, `out_valid` and `out_data` are 0. Samples that are in flight when reset is asserted never emerge.
- R7: Truncation rounds toward minus infinity. With the defaults, x=−1 at rate 3 gives −152 and x=+1 at rate 3 gives 151.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a sample |
| in_rate | input | RATE_W | Decimation rate belonging to this sample |
| in_data | input | DATA_W | Full-precision decimator output, signed |
| out_valid | output | 1 | Marks `out_data` as a scaled sample |
| out_data | output | DATA_W | Gain-normalised sample, signed, SMAX fractional bits |

## Verification
Two functions can fall in the same cycle: a table lookup for a new rate, and the multiply of an earlier sample that was scaled with a different rate. Both are provoked by streaming sixteen samples back to back, each with its own rate, so that up to nine distinct rates sit in the pipeline at once. Each output is judged against an independent model evaluated with the rate of its own sample, and against the cycle in which that sample entered. The test also checks that the correct entry emerges and that it does not take a neighbour's rate.

// File: rtl/cic_gcomp_pkg.sv
package cic_gcomp_pkg;

   localparam int unsigned CALC_W = 128;
   typedef logic [CALC_W-1:0] calc_t;

   // (rate * dd) ^ nsec
   function automatic calc_t gain_of(int unsigned rate, int unsigned dd, int unsigned nsec);
      calc_t g;
      g = calc_t'(1);
      for (int unsigned i = 0; i < nsec; i++) g = g * calc_t'(rate * dd);
      return g;
   endfunction

   function automatic int unsigned floor_log2(calc_t v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < CALC_W; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic int unsigned ceil_log2(calc_t v);
      int unsigned f;
      f = floor_log2(v);
      return (v == (calc_t'(1) << f)) ? f : f + 1;
   endfunction

   // floor(2^(frac+s) / g): reciprocal of the fine factor, frac fractional bits
   function automatic calc_t recip_of(int unsigned rate, int unsigned dd,
                                      int unsigned nsec, int unsigned frac);
      calc_t g;
      int unsigned s;
      g = gain_of(rate, dd, nsec);
      s = floor_log2(g);
      return (calc_t'(1) << (frac + s)) / g;
   endfunction

endpackage

// File: rtl/gcomp_delay.sv
module gcomp_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] pipe [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/gcomp_table.sv
module gcomp_table
   import cic_gcomp_pkg::*;
#(
   parameter int RATE_MAX   = 16,
   parameter int DIFF_DELAY = 1,
   parameter int SECTIONS   = 3,
   parameter int RATE_W     = 12,
   parameter int FRAC_W     = 18,
   parameter int SHIFT_MAX  = 12,
   parameter int SH_W       = 4,
   localparam int COEF_W    = FRAC_W + 1,
   localparam int IDX_W     = $clog2(RATE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic [SH_W-1:0]   shamt_q,
   output logic [COEF_W-1:0] coef_q
);
   logic [SH_W-1:0]   sh_tab [RATE_MAX+1];
   logic [COEF_W-1:0] cf_tab [RATE_MAX+1];
   logic [IDX_W-1:0]  idx;

   // one entry per rate, rates 0 and 1 carry the rate-2 values
   for (genvar r = 0; r <= RATE_MAX; r++) begin : g_rate
      localparam int unsigned RR = (r < 2) ? 2 : r;
      localparam int unsigned SH =
         SHIFT_MAX - floor_log2(gain_of(RR, DIFF_DELAY, SECTIONS));
      localparam calc_t CF = recip_of(RR, DIFF_DELAY, SECTIONS, FRAC_W);
      assign sh_tab[r] = SH_W'(SH);
      assign cf_tab[r] = CF[COEF_W-1:0];
   end

   always_comb begin
      if (rate < RATE_W'(2))                idx = IDX_W'(2);
      else if (rate > RATE_W'(RATE_MAX))    idx = IDX_W'(RATE_MAX);
      else                                  idx = rate[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shamt_q <= '0;
         coef_q  <= '0;
      end else begin
         shamt_q <= sh_tab[idx];
         coef_q  <= cf_tab[idx];
      end
   end
endmodule

// File: rtl/gcomp_scale.sv
module gcomp_scale #(
   parameter int DATA_W    = 28,
   parameter int SHIFT_MAX = 12,
   parameter int SH_W      = 4,
   parameter int FRAC_W    = 18,
   localparam int COEF_W   = FRAC_W + 1,
   localparam int SHW      = DATA_W + SHIFT_MAX,
   localparam int PW       = SHW + COEF_W + 1,
   localparam int TOP_W    = PW - FRAC_W - DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] data_in,
   input  logic [SH_W-1:0]          shamt,
   input  logic [COEF_W-1:0]        coef,
   output logic signed [DATA_W-1:0] res_q
);
   logic signed [SHW-1:0]    sh_q;
   logic signed [COEF_W:0]   coef_d;
   logic signed [PW-1:0]     prod_q;
   logic [FRAC_W-1:0]        frac_unused;
   logic [TOP_W-1:0]         top_unused;
   logic signed [DATA_W-1:0] trunc;

   assign {top_unused, trunc, frac_unused} = prod_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         coef_d <= '0;
         prod_q <= '0;
         res_q  <= '0;
      end else begin
         // stage 2: coarse shift to the max-rate format
         sh_q   <= SHW'(data_in) <<< shamt;
         coef_d <= $signed({1'b0, coef});
         // stage 3: fine reciprocal multiply
         prod_q <= PW'(sh_q) * PW'(coef_d);
         // stage 4: drop fraction bits (floor)
         res_q  <= trunc;
      end
   end
endmodule

// File: rtl/cic_gain_comp.sv
module cic_gain_comp
   import cic_gcomp_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int RATE_MAX   = 16,
   parameter int DIFF_DELAY = 1,
   parameter int SECTIONS   = 3,
   parameter int RATE_W     = 12,
   parameter int FRAC_W     = 18,
   localparam int GB_MAX    = ceil_log2(gain_of(RATE_MAX, DIFF_DELAY, SECTIONS)),
   localparam int SHIFT_MAX = floor_log2(gain_of(RATE_MAX, DIFF_DELAY, SECTIONS)),
   localparam int DATA_W    = IN_W + GB_MAX
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [RATE_W-1:0]        in_rate,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int LAT    = 9;
   localparam int CORE   = 4;
   localparam int PAD    = LAT - CORE;
   localparam int SH_W   = $clog2(SHIFT_MAX + 1);
   localparam int COEF_W = FRAC_W + 1;

   initial begin
      assert (RATE_MAX >= 2) else $error("RATE_MAX must be at least 2");
      assert (DIFF_DELAY >= 1 && SECTIONS >= 1) else $error("bad M or N");
      assert (RATE_W >= $clog2(RATE_MAX + 1)) else $error("RATE_W too narrow");
      assert (GB_MAX + FRAC_W + 2 < int'(CALC_W)) else $error("gain too wide");
   end

   logic signed [DATA_W-1:0] data_s1;
   logic [SH_W-1:0]          shamt_s1;
   logic [COEF_W-1:0]        coef_s1;
   logic signed [DATA_W-1:0] res_s4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_s1 <= '0;
      else        data_s1 <= in_data;
   end

   gcomp_table #(
      .RATE_MAX(RATE_MAX), .DIFF_DELAY(DIFF_DELAY), .SECTIONS(SECTIONS),
      .RATE_W(RATE_W), .FRAC_W(FRAC_W), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .rate(in_rate),
      .shamt_q(shamt_s1), .coef_q(coef_s1)
   );

   gcomp_scale #(
      .DATA_W(DATA_W), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W), .FRAC_W(FRAC_W)
   ) u_scale (
      .clk(clk), .rst_n(rst_n), .data_in(data_s1),
      .shamt(shamt_s1), .coef(coef_s1), .res_q(res_s4)
   );

   logic [DATA_W-1:0] data_pad;

   gcomp_delay #(.W(DATA_W), .DEPTH(PAD)) u_data_pad (
      .clk(clk), .rst_n(rst_n), .d(res_s4), .q(data_pad)
   );
   assign out_data = $signed(data_pad);

   gcomp_delay #(.W(1), .DEPTH(LAT)) u_valid_pipe (
      .clk(clk), .rst_n(rst_n), .d(in_valid), .q(out_valid)
   );
endmodule

// File: rtl/cic_gain_comp_chk.sv
module cic_gain_comp_chk #(
   parameter int DATA_W = 28
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_data,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data
);
   logic [3:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst < 4'd9) since_rst <= since_rst + 4'd1;
   end

   // R1: strobe follows input strobe by nine edges
   a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd9) |-> (out_valid == $past(in_valid, 9)));

   // R6: nothing emerges before the pipeline has refilled after reset
   a_r6_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 4'd9) |-> !out_valid);

   // R2: zero in gives zero out
   a_r2_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd9 && out_valid && $past(in_data, 9) == '0) |-> (out_data == '0));

   // R2: sign of the sample survives scaling
   a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd9 && out_valid) |-> (out_data[DATA_W-1] == $past(in_data[DATA_W-1], 9)));
endmodule

bind cic_gain_comp cic_gain_comp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_cic_gain_comp.sv
module tb_cic_gain_comp;
   localparam int IN_W = 16, RMAX = 16, DD = 1, NS = 3, RATE_W = 12, FRAC = 18;
   localparam int SMAX = 12;           // floor(log2(16^3))
   localparam int DW   = IN_W + 12;    // 28
   localparam int NV   = 16;

   localparam int     V_RATE [NV] = '{2, 3, 5, 7, 16, 9, 11, 13, 4, 6, 8, 10, 12, 14, 15, 16};
   localparam longint V_X    [NV] = '{1000, -1000, 262143, -262144, 0, 123456, -77777, 1,
                                      -1, 200000, -5, 31415, -262144, 99999, -12345, 262143};

   logic clk = 0;
   logic rst_n = 0;
   logic in_valid = 0;
   logic [RATE_W-1:0] in_rate = '0;
   logic signed [DW-1:0] in_data = '0;
   logic out_valid;
   logic signed [DW-1:0] out_data;

   always #2 clk = ~clk;

   cic_gain_comp #(.IN_W(IN_W), .RATE_MAX(RMAX), .DIFF_DELAY(DD), .SECTIONS(NS),
                   .RATE_W(RATE_W), .FRAC_W(FRAC)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rate(in_rate),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

   typedef struct { longint val; int cyc; string tag; } exp_t;
   exp_t expq[$];
   int cyc = 0;
   int checks = 0, errors = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, longint act, longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic longint ref_out(int rate, longint x);
      int r, s;
      longint g, c, v;
      r = (rate < 2) ? 2 : ((rate > RMAX) ? RMAX : rate);
      g = 1;
      for (int i = 0; i < NS; i++) g = g * longint'(r * DD);
      s = 0;
      for (int i = 0; i < 62; i++) if ((longint'(1) << i) <= g) s = i;
      c = (longint'(1) << (FRAC + s)) / g;
      v = (x * (longint'(1) << (SMAX - s))) * c;
      return v >>> FRAC;
   endfunction

   task automatic beat(int rate, longint x, longint expv, string tag);
      @(negedge clk);
      in_valid = 1;
      in_rate  = RATE_W'(rate);
      in_data  = x[DW-1:0];
      expq.push_back('{val: expv, cyc: cyc, tag: tag});
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0;
         in_rate  = RATE_W'(i + 3);
         in_data  = DW'(i * 7777 + 55);
      end
   endtask

   // output monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
               check("R1 unexpected out_valid", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check({e.tag, " data"}, longint'(out_data), e.val);
               check("R1 latency", longint'(cyc - e.cyc), 9);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R6: reset state
      repeat (3) @(negedge clk);
      check("R6 out_valid in reset", longint'(out_valid), 0);
      check("R6 out_data in reset", longint'(out_data), 0);
      @(negedge clk) rst_n = 1;
      idle(4);
      check("R6 quiet after release", longint'(out_valid), 0);

      // R4 / R2: back-to-back stream, new rate every beat
      for (int i = 0; i < NV; i++)
         beat(V_RATE[i], V_X[i], ref_out(V_RATE[i], V_X[i]), "R4 R2 stream");
      idle(12);

      // R3: power-of-two gains, expected written directly
      beat(16, 12345, 12345, "R3 rate16 identity");
      beat(4, -777, -777 * 64, "R3 rate4 shift");
      beat(2, 1000, 1000 * 512, "R3 rate2 shift");
      // R2: full-scale corners at max rate
      beat(16, -134217728, -134217728, "R2 negative full scale");
      beat(16, 134213632, 134213632, "R2 positive full scale");
      // R7: floor truncation
      beat(3, -1, -152, "R7 floor negative");
      beat(3, 1, 151, "R7 floor positive");
      // R5: clamping of out-of-range rates
      beat(0, 1000, 512000, "R5 rate0 as 2");
      beat(1, -3, -1536, "R5 rate1 as 2");
      beat(100, 4242, 4242, "R5 rate100 as max");
      beat(4095, -9, -9, "R5 rate4095 as max");
      idle(12);

      // R1: sparse strobes with junk data in between
      for (int i = 0; i < 6; i++) begin
         beat(5 + i, 5000 - i * 1700, ref_out(5 + i, 5000 - i * 1700), "R1 sparse");
         idle(i % 3 + 1);
      end
      idle(12);
      check("R1 all samples emerged", longint'(expq.size()), 0);

      // R6: reset while samples are in flight
      beat(7, 111, 0, "R6 flushed");
      beat(8, 222, 0, "R6 flushed");
      beat(9, 333, 0, "R6 flushed");
      @(negedge clk);
      in_valid = 0;
      rst_n = 0;
      expq.delete();
      @(negedge clk);
      check("R6 out_valid after mid-run reset", longint'(out_valid), 0);
      check("R6 out_data after mid-run reset", longint'(out_data), 0);
      @(negedge clk) rst_n = 1;
      idle(14);
      check("R6 no stale output", longint'(out_valid), 0);

      done = 1;
      finish_run();
   end
endmodule